// File: doc/BRIEF.md
# Byte-Lane Dual-Port Memory Controller

This block is a clocked model of a memory with two fully independent access ports, called left and right. Each port samples its own control strobes every clock and sorts them into one of a small set of modes: power-down, byte-deselect, byte-lane write, byte-lane read, read with outputs held off, semaphore-only access, and the forbidden mix of semaphore and memory access. Every strobe is active low. Either port may reach any word at any time, and both ports may address the same word in the same clock.

The word is split into an upper byte lane (bits 15..8) and a lower byte lane (bits 7..0). Each lane has its own select and its own output-drive flag, so an external pad ring can tristate each lane separately. Read data and the drive flags are registered and appear one clock after the request. A per-port flag pulses one clock after a forbidden combination is sampled. The semaphore flags themselves live in another block, so here a semaphore strobe only blocks memory access.

The depth is set by `ADDR_W` (2**ADDR_W words). Setting it to 14 gives the full 16384-word array, and the default is kept smaller. The data width is two byte lanes.

Top module: `dpr_core`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. Both ports may read any location in the same clock, including the same location, and each port gets that word.
- R2: A read (chip enable 0, read/write 1, output enable 0, semaphore select 1) with a byte select at 0 raises that lane's drive flag in the next clock. In that same clock, that lane of the port's read data carries the stored byte.
- R3: With chip enable 1 and semaphore select 1 (power-down), the port drives no lane in the next clock and writes nothing.
- R4: With both byte selects at 1, the port drives no lane, writes nothing and raises no forbidden flag, whatever its other strobes are.
- R5: A write (chip enable 0, read/write 0, semaphore select 1) with upper select 0 stores bits 15..8, and with lower select 0 stores bits 7..0. Either lane can be written alone or both together. Output enable has no effect on writes.
- R6: During a read, a lane whose select is 1 has its drive flag at 0, and its read data bits are 0 in the following clock.
- R7: Output enable at 1 forces both drive flags to 0 in the next clock.
- R8: Semaphore select 0 together with chip enable 0 and either byte select 0 is forbidden. It writes nothing, and the port's forbidden flag is 1 in the next clock only.
- R9: Semaphore select 0 with chip enable 1 touches no memory word, drives no lane and raises no forbidden flag.
- R10: When both ports write the same word in the same clock, each lane that both ports enable takes the left port's data. A lane that only one port enables takes that port's data.
- R11: A read in the same clock as a write to the same word returns the contents from before the write.
- R12: While reset is low, all drive flags, read data and forbidden flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, undriven lanes 0 |
| l_drv_hi | output | 1 | Left upper lane drive flag |
| l_drv_lo | output | 1 | Left lower lane drive flag |
| l_forbid | output | 1 | Left forbidden-access pulse |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, undriven lanes 0 |
| r_drv_hi | output | 1 | Right upper lane drive flag |
| r_drv_lo | output | 1 | Right lower lane drive flag |
| r_forbid | output | 1 | Right forbidden-access pulse |

## Verification
The bench builds the block with ADDR_W = 6, a 64-word array that is filled completely through the ports before the random phase. Random addresses are further limited to the lowest eight words, so same-address collisions between the ports occur often. This makes left-wins lane merging and read-during-write ordering common events rather than rare ones. The default 16-bit width keeps both byte lanes and their independent selects in play.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [2:0] {
    M_PWRDN, M_DESEL, M_WRITE, M_READ, M_OUTOFF, M_SEMOP, M_FORBID
  } port_mode_e;

  typedef struct packed {
    logic ce_n;
    logic rw_n;
    logic oe_n;
    logic ub_n;
    logic lb_n;
    logic sem_n;
  } port_ctl_t;

  // lane bit 1 = upper byte, bit 0 = lower byte
  typedef struct packed {
    logic [1:0] wr_lane;
    logic [1:0] rd_lane;
    logic       forbid;
  } port_dec_t;

  function automatic port_mode_e classify(input port_ctl_t c);
    logic [1:0] sel;
    port_mode_e m;
    sel = {~c.ub_n, ~c.lb_n};
    if (!c.sem_n)          m = (!c.ce_n && sel != 2'b00) ? M_FORBID : M_SEMOP;
    else if (c.ce_n)       m = M_PWRDN;
    else if (sel == 2'b00) m = M_DESEL;
    else if (!c.rw_n)      m = M_WRITE;
    else if (c.oe_n)       m = M_OUTOFF;
    else                   m = M_READ;
    return m;
  endfunction

  function automatic port_dec_t decode_port(input port_ctl_t c);
    port_dec_t  d;
    port_mode_e m;
    logic [1:0] sel;
    sel       = {~c.ub_n, ~c.lb_n};
    m         = classify(c);
    d.wr_lane = (m == M_WRITE) ? sel : 2'b00;
    d.rd_lane = (m == M_READ)  ? sel : 2'b00;
    d.forbid  = (m == M_FORBID);
    return d;
  endfunction

endpackage

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl
  import dpr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_ctl_t         ctl,
  input  logic [DATA_W-1:0] rd_word,
  output port_dec_t         dec,
  output logic [1:0]        drive_q,
  output logic              forbid_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int BYTE_W = DATA_W / 2;

  assign dec = decode_port(ctl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q  <= 2'b00;
      forbid_q <= 1'b0;
    end else begin
      drive_q  <= dec.rd_lane;
      forbid_q <= dec.forbid;
    end
  end

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    assign rdata[ln*BYTE_W +: BYTE_W] = drive_q[ln] ? rd_word[ln*BYTE_W +: BYTE_W] : '0;
  end

  // R2
  read_upper_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.ce_n && ctl.rw_n && !ctl.oe_n && ctl.sem_n && !ctl.ub_n) |=> drive_q[1]);
  // R3
  pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ce_n && ctl.sem_n) |=> (drive_q == 2'b00));
  // R4
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ub_n && ctl.lb_n) |=> (drive_q == 2'b00 && !forbid_q));
  // R7
  oe_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.oe_n |=> (drive_q == 2'b00));
  // R8
  forbid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.sem_n && !ctl.ce_n && (!ctl.ub_n || !ctl.lb_n)) |=> forbid_q);
  // R8
  forbid_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forbid_q |-> ($past(dec.wr_lane) == 2'b00));
  // R9
  sem_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.sem_n && ctl.ce_n) |=> (drive_q == 2'b00 && !forbid_q));
endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr    [2],
  input  logic [DATA_W-1:0] wdata   [2],
  input  logic [1:0]        wr_lane [2],
  input  logic              rd_req  [2],
  output logic [DATA_W-1:0] rd_word [2]
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] mem [DEPTH];

  // port 1 (right) is written first, port 0 (left) last so it wins a shared lane
  always_ff @(posedge clk) begin
    for (int p = 1; p >= 0; p--) begin
      for (int ln = 0; ln < 2; ln++) begin
        if (wr_lane[p][ln])
          mem[addr[p]][ln*BYTE_W +: BYTE_W] <= wdata[p][ln*BYTE_W +: BYTE_W];
      end
    end
  end

  // registered read: sees the word before this clock's writes
  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_word[p] <= '0;
      else if (rd_req[p]) rd_word[p] <= mem[addr[p]];
    end
  end

  // R10
  left_wins_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane[0][1] && wr_lane[1][1] && addr[0] == addr[1]) |=>
    (mem[$past(addr[0])][DATA_W-1:BYTE_W] == $past(wdata[0][DATA_W-1:BYTE_W])));
  // R10
  left_wins_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane[0][0] && wr_lane[1][0] && addr[0] == addr[1]) |=>
    (mem[$past(addr[0])][BYTE_W-1:0] == $past(wdata[0][BYTE_W-1:0])));
endmodule

// File: rtl/dpr_core.sv
module dpr_core
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic              l_ub_n,
  input  logic              l_lb_n,
  input  logic              l_sem_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_drv_hi,
  output logic              l_drv_lo,
  output logic              l_forbid,
  input  logic              r_ce_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic              r_ub_n,
  input  logic              r_lb_n,
  input  logic              r_sem_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_drv_hi,
  output logic              r_drv_lo,
  output logic              r_forbid
);
  localparam int NPORT = 2;

  port_ctl_t         ctl     [NPORT];
  port_dec_t         dec     [NPORT];
  logic [ADDR_W-1:0] addr_a  [NPORT];
  logic [DATA_W-1:0] wdata_a [NPORT];
  logic [DATA_W-1:0] rword   [NPORT];
  logic [DATA_W-1:0] rdata_a [NPORT];
  logic [1:0]        wr_lane [NPORT];
  logic              rd_req  [NPORT];
  logic [1:0]        drive   [NPORT];
  logic              forbid  [NPORT];

  assign ctl[0]     = {l_ce_n, l_rw_n, l_oe_n, l_ub_n, l_lb_n, l_sem_n};
  assign ctl[1]     = {r_ce_n, r_rw_n, r_oe_n, r_ub_n, r_lb_n, r_sem_n};
  assign addr_a[0]  = l_addr;
  assign addr_a[1]  = r_addr;
  assign wdata_a[0] = l_wdata;
  assign wdata_a[1] = r_wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_ctl #(.DATA_W(DATA_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl[p]),
      .rd_word  (rword[p]),
      .dec      (dec[p]),
      .drive_q  (drive[p]),
      .forbid_q (forbid[p]),
      .rdata    (rdata_a[p])
    );
    assign wr_lane[p] = dec[p].wr_lane;
    assign rd_req[p]  = |dec[p].rd_lane;
  end

  dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr_a),
    .wdata   (wdata_a),
    .wr_lane (wr_lane),
    .rd_req  (rd_req),
    .rd_word (rword)
  );

  assign l_rdata  = rdata_a[0];
  assign l_drv_hi = drive[0][1];
  assign l_drv_lo = drive[0][0];
  assign l_forbid = forbid[0];
  assign r_rdata  = rdata_a[1];
  assign r_drv_hi = drive[1][1];
  assign r_drv_lo = drive[1][0];
  assign r_forbid = forbid[1];

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!l_drv_hi && !l_drv_lo && !l_forbid && !r_drv_hi && !r_drv_lo && !r_forbid));
  // R8
  forbid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_forbid && l_sem_n) |=> !l_forbid);
endmodule

// File: tb/sim_dpr_core.sv
`timescale 1ns/1ps
module sim_dpr_core;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic ce_n, rw_n, oe_n, ub_n, lb_n, sem_n;
    logic [AW-1:0] a;
    logic [15:0] d;
  } stim_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  stim_t sl, sr;
  logic [15:0] l_rdata, r_rdata;
  logic l_drv_hi, l_drv_lo, l_forbid, r_drv_hi, r_drv_lo, r_forbid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  dpr_core #(.ADDR_W(AW), .DATA_W(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(sl.ce_n), .l_rw_n(sl.rw_n), .l_oe_n(sl.oe_n), .l_ub_n(sl.ub_n),
    .l_lb_n(sl.lb_n), .l_sem_n(sl.sem_n), .l_addr(sl.a), .l_wdata(sl.d),
    .l_rdata(l_rdata), .l_drv_hi(l_drv_hi), .l_drv_lo(l_drv_lo), .l_forbid(l_forbid),
    .r_ce_n(sr.ce_n), .r_rw_n(sr.rw_n), .r_oe_n(sr.oe_n), .r_ub_n(sr.ub_n),
    .r_lb_n(sr.lb_n), .r_sem_n(sr.sem_n), .r_addr(sr.a), .r_wdata(sr.d),
    .r_rdata(r_rdata), .r_drv_hi(r_drv_hi), .r_drv_lo(r_drv_lo), .r_forbid(r_forbid)
  );

  function automatic stim_t mk(logic ce, logic rw, logic oe, logic ub, logic lb,
                               logic sem, logic [AW-1:0] a, logic [15:0] d);
    stim_t s;
    s.ce_n = ce; s.rw_n = rw; s.oe_n = oe; s.ub_n = ub; s.lb_n = lb; s.sem_n = sem;
    s.a = a; s.d = d;
    return s;
  endfunction

  function automatic stim_t idle();
    return mk(1, 1, 1, 1, 1, 1, '0, 16'h0);
  endfunction

  // bench restatement: {forbid, write upper, write lower, read upper, read lower}
  function automatic logic [4:0] bdec(stim_t s);
    logic mem_on, f;
    mem_on = s.sem_n && !s.ce_n;
    f = !s.sem_n && !s.ce_n && (!s.ub_n || !s.lb_n);
    return {f,
            mem_on && !s.rw_n && !s.ub_n,
            mem_on && !s.rw_n && !s.lb_n,
            mem_on && s.rw_n && !s.oe_n && !s.ub_n,
            mem_on && s.rw_n && !s.oe_n && !s.lb_n};
  endfunction

  function automatic string tag_of(stim_t s);
    if (!s.sem_n && !s.ce_n && (!s.ub_n || !s.lb_n)) return "R8";
    if (!s.sem_n) return "R9";
    if (s.ce_n) return "R3";
    if (s.ub_n && s.lb_n) return "R4";
    if (!s.rw_n) return "R5";
    if (s.oe_n) return "R7";
    return "R6";
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(stim_t l, stim_t r, string dtag = "R2");
    logic [4:0] bl, br;
    logic [15:0] wl, wr, el, er;
    sl = l; sr = r;
    bl = bdec(l); br = bdec(r);
    wl = ref_mem[l.a]; wr = ref_mem[r.a];
    el = {bl[1] ? wl[15:8] : 8'h00, bl[0] ? wl[7:0] : 8'h00};
    er = {br[1] ? wr[15:8] : 8'h00, br[0] ? wr[7:0] : 8'h00};
    // right first, left last: left wins a shared lane
    if (br[3]) ref_mem[r.a][15:8] = r.d[15:8];
    if (br[2]) ref_mem[r.a][7:0]  = r.d[7:0];
    if (bl[3]) ref_mem[l.a][15:8] = l.d[15:8];
    if (bl[2]) ref_mem[l.a][7:0]  = l.d[7:0];
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(l), "left drive", {14'b0, l_drv_hi, l_drv_lo}, {14'b0, bl[1:0]});
    chk(tag_of(r), "right drive", {14'b0, r_drv_hi, r_drv_lo}, {14'b0, br[1:0]});
    chk(dtag, "left rdata", l_rdata, el);
    chk(dtag, "right rdata", r_rdata, er);
    chk("R8", "left forbid", {15'b0, l_forbid}, {15'b0, bl[4]});
    chk("R8", "right forbid", {15'b0, r_forbid}, {15'b0, br[4]});
  endtask

  function automatic stim_t rnd();
    stim_t s;
    s.ce_n  = ($urandom % 5) == 0;
    s.rw_n  = $urandom % 2;
    s.oe_n  = ($urandom % 5) == 0;
    s.ub_n  = ($urandom % 4) == 0;
    s.lb_n  = ($urandom % 4) == 0;
    s.sem_n = ($urandom % 8) != 0;
    s.a     = AW'($urandom % 8);
    s.d     = 16'($urandom);
    return s;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    sl = idle(); sr = idle();
    // R12: reset holds every output at zero, even with a read requested
    sl = mk(0, 1, 0, 0, 0, 1, 6'd1, 16'h0);
    repeat (3) @(negedge clk);
    chk("R12", "reset drive", {12'b0, l_drv_hi, l_drv_lo, r_drv_hi, r_drv_lo}, 16'h0);
    chk("R12", "reset rdata", l_rdata | r_rdata, 16'h0);
    chk("R12", "reset forbid", {14'b0, l_forbid, r_forbid}, 16'h0);
    sl = idle();
    @(negedge clk);
    rst_n = 1'b1;

    // preload every word; output enable low has no effect on writes (R5)
    for (int i = 0; i < DEPTH; i++)
      step(mk(0, 0, 0, 0, 0, 1, AW'(i), 16'((i * 16'h0101) ^ 16'hA5C3)), idle(), "R5");

    // R1: both ports read the same word, then different words
    step(mk(0, 1, 0, 0, 0, 1, 6'd3, 0), mk(0, 1, 0, 0, 0, 1, 6'd3, 0), "R1");
    step(mk(0, 1, 0, 0, 0, 1, 6'd4, 0), mk(0, 1, 0, 0, 0, 1, 6'd60, 0), "R1");
    // R5: upper lane alone, then lower lane alone
    step(mk(0, 0, 1, 0, 1, 1, 6'd5, 16'hBEEF), idle(), "R5");
    step(mk(0, 1, 0, 0, 0, 1, 6'd5, 0), idle(), "R5");
    step(idle(), mk(0, 0, 0, 1, 0, 1, 6'd5, 16'h1234), "R5");
    step(idle(), mk(0, 1, 0, 0, 0, 1, 6'd5, 0), "R5");
    // R6: single-lane reads
    step(mk(0, 1, 0, 0, 1, 1, 6'd6, 0), mk(0, 1, 0, 1, 0, 1, 6'd6, 0), "R6");
    // R7: output enable high during a read
    step(mk(0, 1, 1, 0, 0, 1, 6'd6, 0), mk(0, 1, 1, 0, 0, 1, 6'd7, 0), "R7");
    // R3 and R4: blocked writes, then read back
    step(mk(1, 0, 0, 0, 0, 1, 6'd8, 16'hDEAD), mk(0, 0, 0, 1, 1, 1, 6'd8, 16'hF00D), "R3");
    step(mk(0, 1, 0, 0, 0, 1, 6'd8, 0), idle(), "R4");
    // R8: forbidden write on left, then back-to-back and read back
    step(mk(0, 0, 0, 0, 0, 0, 6'd9, 16'h5555), idle(), "R8");
    step(mk(0, 1, 0, 0, 0, 1, 6'd9, 0), idle(), "R8");
    step(mk(0, 0, 0, 1, 0, 0, 6'd9, 16'h7777), mk(0, 0, 0, 0, 1, 0, 6'd9, 16'h6666), "R8");
    step(idle(), idle(), "R8");
    // R9: semaphore-only access on both ports
    step(mk(1, 0, 0, 0, 0, 0, 6'd9, 16'h4444), mk(1, 1, 0, 0, 0, 0, 6'd9, 0), "R9");
    step(mk(0, 1, 0, 0, 0, 1, 6'd9, 0), idle(), "R9");
    // R10: both ports write one word
    step(mk(0, 0, 0, 0, 0, 1, 6'd10, 16'h1111), mk(0, 0, 0, 0, 0, 1, 6'd10, 16'h2222), "R10");
    step(mk(0, 1, 0, 0, 0, 1, 6'd10, 0), idle(), "R10");
    step(mk(0, 0, 0, 0, 1, 1, 6'd10, 16'h3333), mk(0, 0, 0, 0, 0, 1, 6'd10, 16'h4444), "R10");
    step(idle(), mk(0, 1, 0, 0, 0, 1, 6'd10, 0), "R10");
    // R11: read during write to the same word returns old data, then new
    step(mk(0, 0, 0, 0, 0, 1, 6'd11, 16'h9A9A), mk(0, 1, 0, 0, 0, 1, 6'd11, 0), "R11");
    step(idle(), mk(0, 1, 0, 0, 0, 1, 6'd11, 0), "R11");
    step(mk(0, 1, 0, 0, 0, 1, 6'd12, 0), mk(0, 0, 0, 0, 0, 1, 6'd12, 16'h0F0F), "R11");

    // random mix, tags chosen per stimulus
    for (int n = 0; n < 3000; n++) step(rnd(), rnd(), "R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule